// File: doc/BRIEF.md
# Message Interrupt Status Controller

This block turns the end of each terminal bus message, and the boundary events reported by a circular buffer manager, into latched interrupt causes and one interrupt request line. Every message-end strobe carries the message's subaddress (or mode-code number), its direction, a broadcast flag, a mode-code flag and an error flag. The block qualifies each strobe against a set of programmable enables and sets sticky cause bits for every enable the message satisfies.

The causes sit in two status fields that the host sees together as one status word. Reading that word clears both fields in a single operation. The interrupt request is the OR of all pending causes, gated by a master enable that has no effect on latching. Software programs the enables through a small write port. One select value addresses the control bits. Four more select values address the 2^SA_W-bit masks for receive, transmit, broadcast and mode-code messages.

Top module: `msg_irq_status`

## Requirements
- R1: After reset all enables and masks are zero, `status` is 0 and `irq` is low.
- R2: When control bit 1 (global enable) is set, every `msg_done` strobe sets status bit 0.
- R3: When control bit 2 (error enable) is set, a `msg_done` strobe with `msg_err` high sets status bit 1, and a strobe with `msg_err` low leaves that bit unchanged.
- R4: A `msg_done` strobe with `msg_is_mc` low picks one mask, in this order of priority: the broadcast mask (select 3) if `msg_bcast` is high, otherwise the transmit mask (select 2) if `msg_dir` is high, otherwise the receive mask (select 1). If that mask's bit at index `msg_sa` is set, the strobe sets status bit 2 and one class bit: bit 6 for receive, bit 7 for transmit or bit 8 for broadcast.
- R5: A `msg_done` strobe with `msg_is_mc` high sets status bit 3 when bit `msg_sa` of the mode-code mask (select 4) is set. It never sets bits 2 or 6 to 8.
- R6: When control bit 3 is set, a `buf_half` pulse sets status bit 4.
- R7: When control bit 4 is set, a `buf_full` pulse sets status bit 5.
- R8: A set status bit stays set until the status word is read.
- R9: A cycle with `stat_rd` high returns the current status and clears it on the next edge. An event qualified in that same cycle remains set.
- R10: `irq` is high exactly when control bit 0 (master enable) is set and any status bit is set. The master enable does not change which causes are latched.
- R11: A `cfg_we` write loads `cfg_wdata` into the register addressed by `cfg_sel`: select 0 loads the control bits [4:0] and selects 1 to 4 load the masks. Changed enables take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 2^SA_W | Configuration write data |
| msg_done | input | 1 | Message-end strobe |
| msg_sa | input | SA_W | Subaddress or mode-code number |
| msg_dir | input | 1 | 1 = transmit, 0 = receive |
| msg_bcast | input | 1 | Broadcast message |
| msg_is_mc | input | 1 | Mode-code message |
| msg_err | input | 1 | Message ended with error |
| buf_half | input | 1 | Circular buffer reached midpoint |
| buf_full | input | 1 | Circular buffer reached end |
| stat_rd | input | 1 | Status read (clears on next edge) |
| status | output | 9 | Cause bits [5:0] and class bits [8:6] |
| irq | output | 1 | Interrupt request |

## Verification
The in-module assertions check four behaviours on every cycle. Status bits never drop without a read. A read with no event clears the whole word. `irq` never rises with nothing pending. An enabled error, midpoint or end event always lands in the status word. Only the bench's scenarios can show the parts that depend on configuration contents. These are the class priority among broadcast, transmit and receive, the mode-code mask lookup, the kept event that arrives during a read, and master-enable gating while causes keep latching.

// File: rtl/msg_irq_status.sv
module msg_irq_status #(
  parameter int SA_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [2:0]            cfg_sel,
  input  logic [(1<<SA_W)-1:0]  cfg_wdata,
  input  logic                  msg_done,
  input  logic [SA_W-1:0]       msg_sa,
  input  logic                  msg_dir,
  input  logic                  msg_bcast,
  input  logic                  msg_is_mc,
  input  logic                  msg_err,
  input  logic                  buf_half,
  input  logic                  buf_full,
  input  logic                  stat_rd,
  output logic [8:0]            status,
  output logic                  irq
);
  localparam int NSA = 1 << SA_W;

  logic [4:0]     ctl;
  logic [NSA-1:0] rx_m, tx_m, bc_m, mc_m;
  logic [8:0]     st, set_v;
  logic           sa_hit, mc_hit;

  assign sa_hit = msg_bcast ? bc_m[msg_sa] : (msg_dir ? tx_m[msg_sa] : rx_m[msg_sa]);
  assign mc_hit = mc_m[msg_sa];

  always_comb begin
    set_v    = '0;
    set_v[0] = msg_done & ctl[1];
    set_v[1] = msg_done & msg_err & ctl[2];
    set_v[2] = msg_done & ~msg_is_mc & sa_hit;
    set_v[3] = msg_done & msg_is_mc & mc_hit;
    set_v[4] = buf_half & ctl[3];
    set_v[5] = buf_full & ctl[4];
    set_v[6] = set_v[2] & ~msg_bcast & ~msg_dir;
    set_v[7] = set_v[2] & ~msg_bcast & msg_dir;
    set_v[8] = set_v[2] & msg_bcast;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl  <= '0;
      rx_m <= '0;
      tx_m <= '0;
      bc_m <= '0;
      mc_m <= '0;
      st   <= '0;
    end else begin
      st <= (stat_rd ? 9'd0 : st) | set_v;
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: ctl  <= cfg_wdata[4:0];
          3'd1: rx_m <= cfg_wdata;
          3'd2: tx_m <= cfg_wdata;
          3'd3: bc_m <= cfg_wdata;
          3'd4: mc_m <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  assign status = st;
  assign irq    = ctl[0] & (|st);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((status & $past(status)) == $past(status)));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !msg_done && !buf_half && !buf_full) |=> (status == 9'd0));

  assert_irq_needs_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|status));

  assert_err_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_done && msg_err && ctl[2]) |=> status[1]);

  assert_half_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_half && ctl[3]) |=> status[4]);

  assert_full_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && ctl[4]) |=> status[5]);
endmodule

// File: tb/test_msg_irq_status.sv
`timescale 1ns/1ps
module test_msg_irq_status;
  localparam int SA_W = 5;
  localparam int NSA  = 1 << SA_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [2:0] cfg_sel = 0; logic [NSA-1:0] cfg_wdata = 0;
  logic msg_done = 0, msg_dir = 0, msg_bcast = 0, msg_is_mc = 0, msg_err = 0;
  logic [SA_W-1:0] msg_sa = 0;
  logic buf_half = 0, buf_full = 0, stat_rd = 0;
  logic [8:0] status;
  logic irq;

  int total = 0, bad = 0;
  logic [4:0] m_ctl;
  logic [NSA-1:0] m_rx, m_tx, m_bc, m_mc;
  logic [8:0] m_st;

  always #4 clk = ~clk;

  msg_irq_status #(.SA_W(SA_W)) i_msg_irq_status (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .msg_done(msg_done), .msg_sa(msg_sa), .msg_dir(msg_dir), .msg_bcast(msg_bcast),
    .msg_is_mc(msg_is_mc), .msg_err(msg_err), .buf_half(buf_half), .buf_full(buf_full),
    .stat_rd(stat_rd), .status(status), .irq(irq));

  task automatic chk(input logic ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_set();
    logic [8:0] s = '0;
    logic hit;
    hit = msg_bcast ? m_bc[msg_sa] : (msg_dir ? m_tx[msg_sa] : m_rx[msg_sa]);
    s[0] = msg_done & m_ctl[1];
    s[1] = msg_done & msg_err & m_ctl[2];
    s[2] = msg_done & !msg_is_mc & hit;
    s[3] = msg_done & msg_is_mc & m_mc[msg_sa];
    s[4] = buf_half & m_ctl[3];
    s[5] = buf_full & m_ctl[4];
    s[6] = s[2] & !msg_bcast & !msg_dir;
    s[7] = s[2] & !msg_bcast & msg_dir;
    s[8] = s[2] & msg_bcast;
    return s;
  endfunction

  task automatic cyc();
    logic [8:0] s;
    @(posedge clk);
    s = exp_set();
    m_st = (stat_rd ? 9'd0 : m_st) | s;
    if (cfg_we) begin
      case (cfg_sel)
        3'd0: m_ctl = cfg_wdata[4:0];
        3'd1: m_rx = cfg_wdata;
        3'd2: m_tx = cfg_wdata;
        3'd3: m_bc = cfg_wdata;
        3'd4: m_mc = cfg_wdata;
        default: ;
      endcase
    end
    @(negedge clk);
    chk(status == m_st, "R8 model status", status, m_st);
    chk(irq == (m_ctl[0] & (|m_st)), "R10 model irq", {8'd0, irq}, {8'd0, m_ctl[0] & (|m_st)});
    cfg_we = 0; msg_done = 0; buf_half = 0; buf_full = 0; stat_rd = 0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [NSA-1:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d; cyc();
  endtask

  task automatic msg(input logic [SA_W-1:0] sa, input logic dir, input logic bc, input logic mc, input logic er);
    msg_done = 1; msg_sa = sa; msg_dir = dir; msg_bcast = bc; msg_is_mc = mc; msg_err = er; cyc();
  endtask

  task automatic rd_clear();
    stat_rd = 1; cyc();
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1553));
    m_ctl = 0; m_rx = 0; m_tx = 0; m_bc = 0; m_mc = 0; m_st = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(status == 0 && !irq, "R1 reset state", status, 9'd0);

    msg(5'd3, 0, 0, 0, 1);
    chk(status == 0, "R1 nothing enabled after reset", status, 9'd0);

    wr(3'd0, 32'h03);
    msg(5'd1, 0, 0, 0, 0);
    chk(status == 9'h001 && irq, "R2 global end-of-message", status, 9'h001);
    cyc(); cyc();
    chk(status == 9'h001, "R8 sticky", status, 9'h001);
    rd_clear();
    chk(status == 0 && !irq, "R9 read clears", status, 9'd0);

    wr(3'd0, 32'h04);
    msg(5'd2, 0, 0, 0, 0);
    chk(status == 0, "R3 no error no set", status, 9'd0);
    msg(5'd2, 0, 0, 0, 1);
    chk(status == 9'h002, "R3 error end", status, 9'h002);
    chk(!irq, "R10 master off gates irq", {8'd0, irq}, 9'd0);
    stat_rd = 1; msg(5'd2, 0, 0, 0, 1);
    chk(status == 9'h002, "R9 event during read kept", status, 9'h002);
    rd_clear();

    wr(3'd2, 32'h8); wr(3'd1, 32'h10); wr(3'd3, 32'h8);
    msg(5'd3, 1, 0, 0, 0);
    chk(status == 9'h084, "R4 transmit mask hit", status, 9'h084);
    rd_clear();
    msg(5'd3, 0, 0, 0, 0);
    chk(status == 0, "R4 receive mask miss", status, 9'd0);
    msg(5'd4, 0, 0, 0, 0);
    chk(status == 9'h044, "R4 receive mask hit", status, 9'h044);
    rd_clear();
    msg(5'd3, 1, 1, 0, 0);
    chk(status == 9'h104, "R4 broadcast priority", status, 9'h104);
    rd_clear();

    wr(3'd4, 32'h1);
    msg(5'd0, 0, 0, 1, 0);
    chk(status == 9'h008, "R5 mode code hit", status, 9'h008);
    rd_clear();
    msg(5'd3, 1, 0, 1, 0);
    chk(status == 0, "R5 mode code ignores subaddress masks", status, 9'd0);

    wr(3'd0, 32'h19);
    buf_half = 1; cyc();
    chk(status == 9'h010 && irq, "R6 midpoint", status, 9'h010);
    buf_full = 1; cyc();
    chk(status == 9'h030, "R7 end boundary", status, 9'h030);
    wr(3'd7, 32'h0);
    chk(irq && status == 9'h030, "R11 unused select ignored", status, 9'h030);
    rd_clear();
    chk(!irq, "R10 irq drops after read", {8'd0, irq}, 9'd0);

    for (int i = 0; i < 4000; i++) begin
      msg_done  = ($urandom % 3) == 0;
      msg_sa    = SA_W'($urandom);
      msg_dir   = 1'($urandom);
      msg_bcast = ($urandom % 4) == 0;
      msg_is_mc = ($urandom % 4) == 0;
      msg_err   = ($urandom % 3) == 0;
      buf_half  = ($urandom % 8) == 0;
      buf_full  = ($urandom % 8) == 0;
      stat_rd   = ($urandom % 5) == 0;
      cfg_we    = ($urandom % 10) == 0;
      cfg_sel   = 3'($urandom % 6);
      cfg_wdata = {$urandom};
      cyc();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule